// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block sits in the address stage of a load/store unit. Each cycle the unit may present one access: its effective address, an access size code, an access-class code that names which load or store variant issued it, and a valid strobe. The checker works out whether the address is naturally aligned for the size. It then decides whether a misaligned access may go ahead or must be stopped.

Only a fixed set of single word and halfword access classes may run misaligned. Such an access leaves the checker with a split-required flag, so the bus side can break it into aligned pieces. Every other misaligned access raises a usage-fault request in place of the access. All three verdict outputs are registered. They describe the access presented in the previous cycle and stay low after a cycle with no valid access.

Top module: `lsa_align_checker`

## Requirements
- R1: A byte access (size code 0) is never reported unaligned, at any address.
- R2: A halfword access (size code 1) is unaligned exactly when address bit 0 is 1.
- R3: Word (size code 2), doubleword (code 3) and multiple-word (code 4) accesses, and the unused size codes 5 to 7, are unaligned exactly when address bits [1:0] are not both zero.
- R4: An unaligned access with class code 0 to 9 and size code 1 or 2 sets split-required and never raises a fault. Class codes: 0/1 word load (normal/unprivileged), 2/3 halfword load, 4/5 signed halfword load, 6/7 word store, 8/9 halfword store.
- R5: Any other unaligned access (class code 10 to 15, or size code other than 1 or 2) raises the fault request and leaves split-required low.
- R6: An aligned access raises neither the fault request nor split-required, and the unaligned indicator stays low.
- R7: Outputs are registered. An access presented with valid high at a rising edge shows its verdict after that edge, for one cycle only unless another valid access follows.
- R8: After a cycle with valid low, all three outputs are low, whatever the address, size and class inputs hold.
- R9: While reset is asserted, all three outputs are low.

Bit positions at or above 2 in the address have no effect on any verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | An access is presented this cycle |
| i_addr | input | ADDR_W (32) | Effective address of the access |
| i_size | input | 3 | Access size code |
| i_class | input | 4 | Access-class code of the issuing variant |
| o_unaligned | output | 1 | Previous access was misaligned |
| o_fault | output | 1 | Usage-fault request for the previous access |
| o_split | output | 1 | Previous access is permitted misaligned and must be split |

## Verification
The state in this block is one stage of verdict flops, so any fault inside it shows on the ports one cycle after the access that causes it. A wrong flop shows as a verdict that is missing, that lasts into an idle cycle, or that raises fault and split together. A wrong decode shows as a wrong verdict for some pairing of address low bits, size and class. The bench therefore presents every such pairing back to back, so a wrong verdict and a verdict left over from the previous access are both caught in the cycle right after the access.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int SIZE_W  = 3;
  localparam int CLASS_W = 4;
  localparam int N_CLASS = 1 << CLASS_W;

  typedef logic [SIZE_W-1:0]  size_t;
  typedef logic [CLASS_W-1:0] class_t;

  // size codes
  localparam size_t SZ_BYTE  = 3'd0;
  localparam size_t SZ_HALF  = 3'd1;
  localparam size_t SZ_WORD  = 3'd2;
  localparam size_t SZ_DWORD = 3'd3;
  localparam size_t SZ_MULTI = 3'd4;

  // classes allowed to run misaligned: codes 0..9
  localparam logic [N_CLASS-1:0] DEFAULT_PERMIT = 16'h03FF;

  typedef struct packed {
    logic unaligned;
    logic fault;
    logic split;
  } verdict_t;

endpackage

// File: rtl/lsa_align_detect.sv
module lsa_align_detect
  import lsa_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  size_t      size,
  output logic       misaligned
);

  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr_lo[0];
      default: misaligned = |addr_lo;
    endcase
  end

  // R1: byte accesses are never misaligned
  always_comb begin
    a_r1_byte_aligned: assert (!(size == SZ_BYTE && misaligned));
  end

endmodule

// File: rtl/lsa_class_permit.sv
module lsa_class_permit
  import lsa_pkg::*;
#(
  parameter logic [N_CLASS-1:0] PERMIT_MASK = DEFAULT_PERMIT
) (
  input  class_t cls,
  input  size_t  size,
  output logic   permitted
);

  logic [N_CLASS-1:0] hit;
  logic               size_ok;

  for (genvar g = 0; g < N_CLASS; g++) begin : g_cls
    if (PERMIT_MASK[g]) begin : g_on
      assign hit[g] = (cls == class_t'(g));
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  assign size_ok   = (size == SZ_HALF) || (size == SZ_WORD);
  assign permitted = size_ok && (|hit);

  // R5: only single halfword or word accesses may be permitted
  always_comb begin
    a_r5_permit_size: assert (!permitted || size == SZ_HALF || size == SZ_WORD);
  end

endmodule

// File: rtl/lsa_verdict_reg.sv
module lsa_verdict_reg
  import lsa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid,
  input  verdict_t verdict_d,
  output verdict_t verdict_q
);

  verdict_t verdict_nxt;

  always_comb begin
    verdict_nxt = '0;
    if (valid) begin
      verdict_nxt = verdict_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= '0;
    end else begin
      verdict_q <= verdict_nxt;
    end
  end

  // R4/R5: fault and split never together
  a_r4_fault_split_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict_q.fault && verdict_q.split));

  // R5: fault only for misaligned accesses
  a_r5_fault_needs_unal: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_q.fault |-> verdict_q.unaligned);

  // R4: split only for misaligned accesses
  a_r4_split_needs_unal: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_q.split |-> verdict_q.unaligned);

  // R8: idle cycle leaves outputs low
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (verdict_q == '0));

endmodule

// File: rtl/lsa_align_checker.sv
module lsa_align_checker
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [2:0]        i_size,
  input  logic [3:0]        i_class,
  output logic              o_unaligned,
  output logic              o_fault,
  output logic              o_split
);

  logic     misaligned;
  logic     permitted;
  verdict_t verdict_d;
  verdict_t verdict_q;

  lsa_align_detect u_detect (
    .addr_lo    (i_addr[1:0]),
    .size       (i_size),
    .misaligned (misaligned)
  );

  lsa_class_permit #(
    .PERMIT_MASK (DEFAULT_PERMIT)
  ) u_permit (
    .cls       (i_class),
    .size      (i_size),
    .permitted (permitted)
  );

  always_comb begin
    verdict_d.unaligned = misaligned;
    verdict_d.fault     = misaligned && !permitted;
    verdict_d.split     = misaligned && permitted;
  end

  lsa_verdict_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (i_valid),
    .verdict_d (verdict_d),
    .verdict_q (verdict_q)
  );

  assign o_unaligned = verdict_q.unaligned;
  assign o_fault     = verdict_q.fault;
  assign o_split     = verdict_q.split;

endmodule

// File: tb/test_lsa_align_checker.sv
module test_lsa_align_checker;

  logic        clk;
  logic        rst_n;
  logic        i_valid;
  logic [31:0] i_addr;
  logic [2:0]  i_size;
  logic [3:0]  i_class;
  logic        o_unaligned;
  logic        o_fault;
  logic        o_split;

  int checks;
  int errors;

  lsa_align_checker #(.ADDR_W(32)) i_lsa_align_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_valid     (i_valid),
    .i_addr      (i_addr),
    .i_size      (i_size),
    .i_class     (i_class),
    .o_unaligned (o_unaligned),
    .o_fault     (o_fault),
    .o_split     (o_split)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    errors = errors + 1;
    $display("FAIL watchdog: expected end of run, got timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [2:0] ref_verdict(input logic [1:0] a, input logic [2:0] sz,
                                             input logic [3:0] cl);
    logic mis;
    logic ok;
    if (sz == 3'd0)      mis = 1'b0;
    else if (sz == 3'd1) mis = a[0];
    else                 mis = (a != 2'd0);
    ok = (cl <= 4'd9) && (sz == 3'd1 || sz == 3'd2);
    return {mis, mis && !ok, mis && ok};
  endfunction

  function automatic string req_tag(input logic [2:0] exp, input logic [2:0] sz);
    if (exp[1])        return "R5";
    if (exp[0])        return "R4";
    if (sz == 3'd0)    return "R1";
    if (sz == 3'd1)    return "R2/R6";
    return "R3/R6";
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {o_unaligned, o_fault, o_split};
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: {unal,fault,split} actual %b expected %b", tag, act, exp);
    end
  endtask

  logic [2:0] pend;
  logic [2:0] pend_sz;

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    i_valid = 1'b1;
    i_addr  = 32'h3;
    i_size  = 3'd4;
    i_class = 4'd15;
    repeat (3) @(negedge clk);
    check("R9 reset", 3'b000);
    rst_n = 1'b1;
    i_valid = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", 3'b000);

    // full sweep, back to back: address bits 1:0 x size x class
    pend = 3'b000;
    pend_sz = 3'd0;
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 8; s++) begin
        for (int c = 0; c < 16; c++) begin
          i_valid = 1'b1;
          i_addr  = {$urandom()} & 32'hFFFF_FFFC | 32'(a);
          i_size  = 3'(s);
          i_class = 4'(c);
          pend    = ref_verdict(2'(a), 3'(s), 4'(c));
          pend_sz = 3'(s);
          @(negedge clk);
          check(req_tag(pend, pend_sz), pend);
        end
      end
    end

    // R7: single valid pulse gives a one-cycle verdict
    i_valid = 1'b1; i_addr = 32'h1001; i_size = 3'd2; i_class = 4'd0;
    @(negedge clk);
    check("R7 pulse split", 3'b101);
    i_valid = 1'b0;
    @(negedge clk);
    check("R7 pulse ends", 3'b000);

    i_valid = 1'b1; i_addr = 32'h2002; i_size = 3'd3; i_class = 4'd0;
    @(negedge clk);
    check("R7 pulse fault", 3'b110);

    // R8: misaligned inputs with valid low do nothing
    for (int k = 0; k < 16; k++) begin
      i_valid = 1'b0;
      i_addr  = 32'(k) | 32'h1;
      i_size  = 3'(k % 8);
      i_class = 4'(k);
      @(negedge clk);
      check("R8 valid low", 3'b000);
    end

    // R9: reset in mid-stream clears outputs
    i_valid = 1'b1; i_addr = 32'h3; i_size = 3'd1; i_class = 4'd12;
    @(negedge clk);
    check("R5 before reset", 3'b110);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 3'b000);
    @(negedge clk);
    check("R9 held in reset", 3'b000);
    rst_n = 1'b1;
    i_valid = 1'b0;
    @(negedge clk);
    check("R8 after reset", 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule